// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a single memory access may proceed under the protection bits of a page-table entry. Each request presents the entry's user/supervisor, writable and no-execute bits with the current privilege level, the kind of access (data read, data write or instruction fetch), the write-protect control bit and a no-execute enable bit. On the clock edge that samples the strobe, the block registers a verdict: either an allow flag, or a page-fault flag with a four-bit cause code that describes the access that faulted.

Privilege levels 0, 1 and 2 are all treated as supervisor mode and level 3 as user mode. A supervisor write to a read-only page goes through unless write protection is turned on. Instruction fetches honour the no-execute bit only while no-execute enforcement is enabled. The page walk, translation caching and merging of protection bits across table levels all happen upstream. This block sees one combined set of entry bits per request.

Top module: `page_perm_check`

## Requirements
- R1: While reset is asserted and after it is released with no request, `rsp_valid`, `allow`, `fault` and `fault_code` are all 0.
- R2: A request sampled with `req_valid` high at a rising edge shows its verdict right after that edge, with `rsp_valid` high for exactly that one cycle. `allow`, `fault` and `fault_code` then hold unchanged until the next sampled request, whatever the other inputs do.
- R3: At privilege level 3, any access to a page with `pte_user`=0 faults, whatever the access kind.
- R4: At privilege levels 0, 1 and 2, reads and fetches are allowed on both user and supervisor pages, unless R6 or R7 blocks them.
- R5: A level-3 write to a page with `pte_writable`=0 faults, whatever the value of `wp_en`.
- R6: A write at levels 0 to 2 to a page with `pte_writable`=0 is allowed when `wp_en`=0 and faults when `wp_en`=1.
- R7: A fetch from a page with `pte_nx`=1 faults when `nx_en`=1. When `nx_en`=0, `pte_nx` has no effect.
- R8: Data reads are never blocked by `pte_writable` or `pte_nx`.
- R9: Once the first verdict is out, exactly one of `allow` and `fault` is high.
- R10: On a fault, `fault_code` bit 0 is 1 (protection violation), bit 1 is 1 for a write, bit 2 is 1 for level 3, and bit 3 is 1 for a fetch. When the access is allowed, `fault_code` is 0.
- R11: `acc_type` encodes 0 = read, 1 = write, 2 = fetch. The value 3 is handled exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| pte_user | input | 1 | Entry user bit (1 = user page) |
| pte_writable | input | 1 | Entry writable bit (1 = writes allowed) |
| pte_nx | input | 1 | Entry no-execute bit |
| cpl | input | 2 | Current privilege level |
| acc_type | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 as read |
| wp_en | input | 1 | Write-protect enforcement for supervisor writes |
| nx_en | input | 1 | No-execute enforcement enable |
| rsp_valid | output | 1 | One-cycle pulse marking a new verdict |
| allow | output | 1 | Registered verdict: access allowed |
| fault | output | 1 | Registered verdict: page fault |
| fault_code | output | 4 | Fault cause: [0] protection, [1] write, [2] user, [3] fetch |

## Verification
The properties assume that `req_valid` is low while reset is held. They also assume that the request inputs are steady around each sampling edge, so that a single `$past` sample describes the request being judged. The bench drives all inputs on the falling edge and keeps the strobe low throughout reset. Between strobes it changes the entry bits and controls at random, so the hold property is tested against moving inputs and not idle ones. Random requests cover all four `acc_type` codes and all privilege levels. Directed requests cover each write-protect, no-execute and privilege boundary.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

    localparam int CPL_W    = 2;
    localparam int ACC_W    = 2;
    localparam int CODE_W   = 4;
    localparam int USER_CPL = 3;

    typedef enum logic [ACC_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic fetch;
        logic user;
        logic write;
        logic prot;
    } fcode_t;

    typedef struct packed {
        logic   us_viol;
        logic   rw_viol;
        logic   nx_viol;
    } viol_t;

    typedef struct packed {
        logic   rsp_valid;
        logic   allow;
        logic   fault;
        fcode_t code;
    } verdict_t;

endpackage

// File: rtl/pp_priv_decode.sv
module pp_priv_decode #(
    parameter int CPL_W    = 2,
    parameter int USER_CPL = 3
) (
    input  logic [CPL_W-1:0] cpl,
    output logic             is_user
);
    localparam logic [CPL_W-1:0] USER_LVL = CPL_W'(USER_CPL);

    always_comb begin
        is_user = (cpl >= USER_LVL);
    end
endmodule

// File: rtl/pp_rule_eval.sv
module pp_rule_eval
    import page_perm_pkg::*;
(
    input  logic             is_user,
    input  logic             pte_user,
    input  logic             pte_writable,
    input  logic             pte_nx,
    input  logic [ACC_W-1:0] acc_type,
    input  logic             wp_en,
    input  logic             nx_en,
    output logic             is_write,
    output logic             is_fetch,
    output viol_t            viol
);
    always_comb begin
        // code 3 falls through to read handling
        is_write = (acc_e'(acc_type) == ACC_WRITE);
        is_fetch = (acc_e'(acc_type) == ACC_FETCH);

        viol.us_viol = is_user && !pte_user;
        viol.rw_viol = is_write && !pte_writable && (is_user || wp_en);
        viol.nx_viol = is_fetch && pte_nx && nx_en;
    end
endmodule

// File: rtl/pp_fault_encode.sv
module pp_fault_encode
    import page_perm_pkg::*;
(
    input  viol_t  viol,
    input  logic   is_user,
    input  logic   is_write,
    input  logic   is_fetch,
    output logic   fault,
    output fcode_t code
);
    always_comb begin
        fault = viol.us_viol || viol.rw_viol || viol.nx_viol;
        code  = '0;
        if (fault) begin
            code.prot  = 1'b1;
            code.write = is_write;
            code.user  = is_user;
            code.fetch = is_fetch;
        end
    end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import page_perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              pte_user,
    input  logic              pte_writable,
    input  logic              pte_nx,
    input  logic [CPL_W-1:0]  cpl,
    input  logic [ACC_W-1:0]  acc_type,
    input  logic              wp_en,
    input  logic              nx_en,
    output logic              rsp_valid,
    output logic              allow,
    output logic              fault,
    output logic [CODE_W-1:0] fault_code
);
    logic     is_user;
    logic     is_write;
    logic     is_fetch;
    viol_t    viol;
    logic     fault_now;
    fcode_t   code_now;
    verdict_t st_d, st_q;

    pp_priv_decode #(
        .CPL_W    (CPL_W),
        .USER_CPL (USER_CPL)
    ) u_priv (
        .cpl     (cpl),
        .is_user (is_user)
    );

    pp_rule_eval u_rules (
        .is_user      (is_user),
        .pte_user     (pte_user),
        .pte_writable (pte_writable),
        .pte_nx       (pte_nx),
        .acc_type     (acc_type),
        .wp_en        (wp_en),
        .nx_en        (nx_en),
        .is_write     (is_write),
        .is_fetch     (is_fetch),
        .viol         (viol)
    );

    pp_fault_encode u_enc (
        .viol     (viol),
        .is_user  (is_user),
        .is_write (is_write),
        .is_fetch (is_fetch),
        .fault    (fault_now),
        .code     (code_now)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        if (req_valid) begin
            st_d.rsp_valid = 1'b1;
            st_d.fault     = fault_now;
            st_d.allow     = !fault_now;
            st_d.code      = code_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign allow      = st_q.allow;
    assign fault      = st_q.fault;
    assign fault_code = st_q.code;
endmodule

// File: rtl/page_perm_check_sva.sv
module page_perm_check_sva
    import page_perm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              pte_user,
    input logic              pte_writable,
    input logic              pte_nx,
    input logic [CPL_W-1:0]  cpl,
    input logic [ACC_W-1:0]  acc_type,
    input logic              wp_en,
    input logic              nx_en,
    input logic              rsp_valid,
    input logic              allow,
    input logic              fault,
    input logic [CODE_W-1:0] fault_code
);
    // R2: one-cycle response pulse follows each strobe
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2: verdict holds between strobes
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable({allow, fault, fault_code}));
    // R9: verdict is one-hot once produced
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (allow != fault));
    // R3: user access to supervisor page faults
    p_user_sup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpl == 2'd3 && !pte_user) |=> fault);
    // R6: supervisor write to read-only page with WP clear is allowed
    p_wp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpl != 2'd3 && acc_type == 2'd1 && !wp_en) |=> allow);
    // R7: with NX disabled, a supervisor fetch is allowed
    p_nx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpl != 2'd3 && acc_type == 2'd2 && !nx_en) |=> allow);
    // R10: write cause bit tracks the faulting access kind
    p_code_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fault_code[1] == (fault && $past(acc_type) == 2'd1)));
endmodule

bind page_perm_check page_perm_check_sva u_sva (.*);

// File: tb/page_perm_check_tb.sv
module page_perm_check_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic       pte_user, pte_writable, pte_nx;
    logic [1:0] cpl, acc_type;
    logic       wp_en, nx_en;
    logic       rsp_valid, allow, fault;
    logic [3:0] fault_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    page_perm_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .pte_user(pte_user), .pte_writable(pte_writable), .pte_nx(pte_nx),
        .cpl(cpl), .acc_type(acc_type), .wp_en(wp_en), .nx_en(nx_en),
        .rsp_valid(rsp_valid), .allow(allow), .fault(fault),
        .fault_code(fault_code)
    );

    // expected {fault, code} from the requirements
    function automatic logic [4:0] model(input logic u, input logic w,
        input logic x, input logic [1:0] lvl, input logic [1:0] acc,
        input logic wp, input logic nxe);
        logic usr, wr, fe, f;
        usr = (lvl == 2'd3);
        wr  = (acc == 2'd1);
        fe  = (acc == 2'd2);
        f   = (usr && !u) || (wr && !w && (usr || wp)) || (fe && x && nxe);
        return f ? {1'b1, fe, usr, wr, 1'b1} : 5'b0;
    endfunction

    function automatic string tag_of(input logic u, input logic w,
        input logic [1:0] lvl, input logic [1:0] acc);
        if (lvl == 2'd3 && !u) return "R3";
        if (acc == 2'd1) return (lvl == 2'd3) ? "R5" : "R6";
        if (acc == 2'd2) return "R7";
        if (acc == 2'd3) return "R11";
        return (lvl == 2'd3) ? "R8" : "R4";
    endfunction

    task automatic check(input string req, input logic [6:0] act,
                         input logic [6:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic access(input logic u, input logic w, input logic x,
        input logic [1:0] lvl, input logic [1:0] acc, input logic wp,
        input logic nxe, input string req);
        logic [4:0] e;
        @(negedge clk);
        pte_user = u; pte_writable = w; pte_nx = x;
        cpl = lvl; acc_type = acc; wp_en = wp; nx_en = nxe;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        e = model(u, w, x, lvl, acc, wp, nxe);
        check(req, {rsp_valid, allow, fault, fault_code},
              {1'b1, !e[4], e[4], e[3:0]});
    endtask

    task automatic idle_hold();
        logic [6:0] prev;
        prev = {rsp_valid, allow, fault, fault_code};
        pte_user = 1'($urandom); pte_writable = 1'($urandom);
        pte_nx = 1'($urandom); cpl = 2'($urandom);
        acc_type = 2'($urandom); wp_en = 1'($urandom); nx_en = 1'($urandom);
        @(negedge clk);
        // R2: no strobe, verdict unchanged, pulse gone
        check("R2", {rsp_valid, allow, fault, fault_code},
              {1'b0, prev[5:0]});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; req_valid = 1'b0;
        pte_user = 0; pte_writable = 0; pte_nx = 0;
        cpl = 0; acc_type = 0; wp_en = 0; nx_en = 0;
        repeat (3) @(negedge clk);
        check("R1", {rsp_valid, allow, fault, fault_code}, 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rsp_valid, allow, fault, fault_code}, 7'b0);

        // directed corners
        access(0, 1, 0, 2'd3, 2'd0, 0, 0, "R3");
        access(0, 1, 0, 2'd3, 2'd2, 0, 1, "R3");
        access(0, 0, 1, 2'd3, 2'd1, 1, 1, "R10");
        access(1, 1, 0, 2'd2, 2'd0, 0, 0, "R4");
        access(0, 1, 0, 2'd1, 2'd2, 0, 0, "R4");
        access(1, 0, 0, 2'd3, 2'd1, 0, 0, "R5");
        access(0, 0, 0, 2'd0, 2'd1, 0, 0, "R6");
        access(0, 0, 0, 2'd2, 2'd1, 1, 0, "R6");
        access(1, 1, 1, 2'd3, 2'd2, 0, 1, "R7");
        access(1, 1, 1, 2'd3, 2'd2, 0, 0, "R7");
        access(1, 0, 1, 2'd3, 2'd0, 1, 1, "R8");
        access(1, 0, 1, 2'd3, 2'd3, 1, 1, "R11");
        idle_hold();
        idle_hold();

        for (int i = 0; i < 400; i++) begin
            logic u, w, x, wp, nxe;
            logic [1:0] lvl, acc;
            u = 1'($urandom); w = 1'($urandom); x = 1'($urandom);
            wp = 1'($urandom); nxe = 1'($urandom);
            lvl = 2'($urandom); acc = 2'($urandom);
            access(u, w, x, lvl, acc, wp, nxe, tag_of(u, w, lvl, acc));
            if ($urandom_range(0, 3) == 0) idle_hold();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule